// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external byte-wide asynchronous static RAM with a 17-bit address. The host offers one access at a time on a valid/ready request channel. Each request carries a write flag, an address and, for writes, a data byte. The controller turns each access into a timed sequence on the RAM pins: address, two chip enables of opposite polarity, an active-low write strobe, an active-low output enable, and a split data bus (out, in, drive enable) for one bidirectional pad.

Every minimum time the RAM needs is a nanosecond parameter. Each is turned into a clock count by rounding up, with a floor of one clock, using the `CLK_PERIOD_NS` parameter. The controller holds the address and write data from acceptance until the access completes. It raises `rsp_done` for one clock when the access is over, and presents read data on `rsp_rdata` in that same clock.

Back-pressure: `req_ready` is high only while the controller is idle. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, `req_valid` and its payload are ignored and leave no trace. The response side has no back-pressure: the host must take `rsp_rdata` in the cycle `rsp_done` is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle: `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0, `rsp_done`=0 and `req_ready`=1.
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge; `req_write`=1 makes it a write and 0 a read. A request offered while busy has no effect on the RAM contents.
- R3: During a read the chip is selected (`sram_ce1_n`=0, `sram_ce2`=1), `sram_oe_n`=0, `sram_we_n`=1, `sram_dq_oe`=0, and `sram_addr` does not change.
- R4: Read data is captured after exactly RD clocks of active read strobes, where RD = ceil(max(70, 70, 50) ns / period), at least 1 (7 at 10 ns). It is returned on `rsp_rdata` with `rsp_done`, which is high RD+1 edges after the accepting edge.
- R5: A write first holds the chip selected with both strobes high for TURN = ceil(35 ns / period) clocks (4 at 10 ns). It then holds `sram_we_n` low for exactly WP = max(ceil(50/P), ceil(30/P), ceil(70/P) - TURN, 1) clocks (5 at 10 ns). Throughout the pulse, data is driven and the address is stable.
- R6: `sram_dq_oe` is never high while the chip is selected with `sram_oe_n` low, nor within TURN clocks after `sram_oe_n` rises.
- R7: `sram_we_n` and `sram_oe_n` are never low together.
- R8: `rsp_done` is a one-clock pulse, given exactly once per accepted access, and the chip is deselected while the controller is idle.
- R9: For one clock after `sram_we_n` rises, data stays driven and the address is unchanged. The write's `rsp_done` is high TURN+WP+1 edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock pulse at access completion |
| rsp_rdata | output | 8 | Read data, valid with rsp_done of a read |
| sram_addr | output | 17 | RAM address bus |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_in | input | 8 | Data from the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The bench models the RAM pessimistically. Its read data is garbage until the full access time has elapsed, so a controller that samples even one clock early returns wrong bytes. The model also marks its data bus as driven for the release window after output enable rises. A write issued straight after a read therefore shows up a turnaround that is too short as bus contention. Each write pulse is measured against its exact length, and the model checks that address and data stay still through the pulse and the hold clock after it. The bench also offers a stray write while a read is in flight; a controller that latched it would corrupt the byte that is read back later.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_DONE,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_DONE
  } ctrl_state_e;

  // internal active-high view of the pin strobes
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drive;
    logic done;
  } strobe_t;

  // minimum time in ns -> clocks, rounded up, never below one
  function automatic int unsigned ns_to_cycles(int unsigned t_ns, int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

  // R4 / R5 strobe lengths depend on a steady one-per-clock countdown
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rdata_in;
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 7,
  parameter int TURN_CYC = 4,
  parameter int WP_CYC   = 5,
  parameter int TMR_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             sel_o,
  output logic             oe_o,
  output logic             we_o,
  output logic             drive_o,
  output logic             done_o
);

  // RD_SETUP always lasts one clock, the wait covers the rest of RD_CYC
  localparam int RD_WAIT_CYC = (RD_CYC > 1) ? RD_CYC - 1 : 1;

  ctrl_state_e state_q, state_d;
  strobe_t     strb_q;

  function automatic strobe_t decode(ctrl_state_e s);
    strobe_t o;
    o = '0;
    case (s)
      ST_RD_SETUP, ST_RD_WAIT: begin o.sel = 1'b1; o.oe = 1'b1; end
      ST_WR_TURN:              o.sel = 1'b1;
      ST_WR_PULSE:             begin o.sel = 1'b1; o.we = 1'b1; o.drive = 1'b1; end
      ST_WR_RECOVER:           begin o.sel = 1'b1; o.drive = 1'b1; end
      ST_DONE:                 o.done = 1'b1;
      default:                 o = '0;
    endcase
    return o;
  endfunction

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WR_TURN;
          tmr_val = TMR_W'(TURN_CYC - 1);
        end else begin
          state_d = ST_RD_SETUP;
          tmr_val = '0;
        end
      end
      ST_RD_SETUP: if (tmr_expired) begin
        state_d  = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(RD_WAIT_CYC - 1);
      end
      ST_RD_WAIT:    if (tmr_expired) state_d = ST_RD_DONE;
      ST_RD_DONE:    state_d = ST_DONE;
      ST_WR_TURN: if (tmr_expired) begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WP_CYC - 1);
      end
      ST_WR_PULSE:   if (tmr_expired) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= '0;
    end else begin
      state_q <= state_d;
      strb_q  <= decode(state_d);
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == ST_RD_WAIT) && tmr_expired;

  assign sel_o   = strb_q.sel;
  assign oe_o    = strb_q.oe;
  assign we_o    = strb_q.we;
  assign drive_o = strb_q.drive;
  assign done_o  = strb_q.done;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_q.we && strb_q.oe));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.done |=> !strb_q.done);

  assert_no_drive_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.oe |-> !strb_q.drive);

  assert_release_before_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_q.oe) |-> !strb_q.drive);

  assert_write_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.we |-> (strb_q.sel && strb_q.drive));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 50,
  parameter int T_WP_NS       = 50,
  parameter int T_AW_NS       = 70,
  parameter int T_DW_NS       = 30,
  parameter int T_REL_NS      = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int RD_CYC   = int'(umax(umax(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                           ns_to_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                      ns_to_cycles(T_OE_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC = int'(ns_to_cycles(T_REL_NS, CLK_PERIOD_NS));
  localparam int AW_CYC   = int'(ns_to_cycles(T_AW_NS, CLK_PERIOD_NS));
  localparam int AW_LEFT  = (AW_CYC > TURN_CYC) ? AW_CYC - TURN_CYC : 1;
  localparam int WP_CYC   = int'(umax(umax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                           ns_to_cycles(T_DW_NS, CLK_PERIOD_NS)),
                                      AW_LEFT));
  localparam int MAX_CYC  = int'(umax(umax(RD_CYC, TURN_CYC), WP_CYC));
  localparam int TMR_W    = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;
  logic             accept, capture;
  logic             sel, oe, we, drive;

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .WP_CYC  (WP_CYC),
    .TMR_W   (TMR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture),
    .sel_o      (sel),
    .oe_o       (oe),
    .we_o       (we),
    .drive_o    (drive),
    .done_o     (rsp_done)
  );

  sram_wait_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .addr_in (req_addr),
    .wdata_in(req_wdata),
    .capture (capture),
    .rdata_in(sram_dq_in),
    .addr_q  (sram_addr),
    .wdata_q (sram_dq_out),
    .rdata_q (rsp_rdata)
  );

  assign sram_ce1_n = ~sel;
  assign sram_ce2   = sel;
  assign sram_we_n  = ~we;
  assign sram_oe_n  = ~oe;
  assign sram_dq_oe = drive;

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> $stable(sram_addr));

  assert_busy_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(sram_addr));

  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int PER      = 10;
  localparam int RD_EXP   = (70 + PER - 1) / PER;
  localparam int TURN_EXP = (35 + PER - 1) / PER;
  localparam int WP_EXP   = 5;  // max(ceil(50/10), ceil(30/10), 7-4)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in = '0;

  int checks = 0;
  int errors = 0;
  int dones  = 0;
  int issued = 0;

  always #5 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] ram [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] ram_rd(logic [16:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_rd(logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  wire selected = !sram_ce1_n && sram_ce2;
  wire rd_act   = selected && !sram_oe_n && sram_we_n;
  wire wr_act   = selected && !sram_we_n;

  int          rcnt = 0, wcnt = 0, hold = 100;
  logic [16:0] raddr = '0, waddr = '0;
  logic [7:0]  wdat = '0;

  always @(posedge clk) begin
    if (rd_act) begin
      if (rcnt != 0 && sram_addr != raddr)
        check(1'b0, "R3 read address moved", sram_addr, raddr);
      rcnt <= rcnt + 1;
      raddr <= sram_addr;
      sram_dq_in <= (rcnt + 1 >= RD_EXP - 1) ? ram_rd(sram_addr) : ~ram_rd(sram_addr) ^ 8'h3C;
    end else begin
      rcnt <= 0;
      sram_dq_in <= 8'hC3;
    end
    if (selected && !sram_oe_n) hold <= 0;
    else if (hold < 100) hold <= hold + 1;
    if (wr_act) begin
      if (!sram_dq_oe) check(1'b0, "R5 data not driven in pulse", 0, 1);
      if (wcnt != 0 && (sram_addr != waddr || sram_dq_out != wdat))
        check(1'b0, "R5 addr/data moved in pulse", {sram_addr, sram_dq_out}, {waddr, wdat});
      wcnt <= wcnt + 1;
      waddr <= sram_addr;
      wdat <= sram_dq_out;
    end else if (wcnt != 0) begin
      check(wcnt == WP_EXP, "R5 write pulse length", wcnt, WP_EXP);
      check(sram_dq_oe && sram_dq_out == wdat && sram_addr == waddr,
            "R9 hold after strobe", {sram_dq_oe, sram_addr, sram_dq_out}, {1'b1, waddr, wdat});
      ram[int'(waddr)] = wdat;
      wcnt <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sram_dq_oe)
      check(!(selected && !sram_oe_n) && hold >= TURN_EXP, "R6 bus contention", hold, TURN_EXP);
    if (rst_n && !sram_we_n && !sram_oe_n)
      check(1'b0, "R7 both strobes low", 0, 1);
    if (rst_n && rd_act && sram_dq_oe)
      check(1'b0, "R3 driving during read", 1, 0);
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit is_rd; logic [16:0] addr; logic [7:0] data; } item_t;
  item_t sb_q[$];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_done) begin
        dones++;
        if (prev_done) check(1'b0, "R8 done wider than one clock", 2, 1);
        if (sb_q.size() == 0) check(1'b0, "R8 unexpected done", dones, issued);
        else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.is_rd) check(rsp_rdata == it.data, "R4 read data", rsp_rdata, it.data);
        end
      end
      if (req_ready)
        check(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe,
              "R8 idle deselect", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
      prev_done = rsp_done;
    end
  end

  // ---------------- driver ----------------
  task automatic do_access(bit wr, logic [16:0] a, logic [7:0] d, bit stray);
    item_t it;
    int lat;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    it.is_rd = !wr; it.addr = a;
    if (wr) begin ref_mem[int'(a)] = d; it.data = d; end
    else it.data = ref_rd(a);
    sb_q.push_back(it);
    issued++;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && lat < 200) begin
      if (stray && lat == 3) begin
        check(!req_ready, "R2 ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 8'hEE;
      end else req_valid = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (wr) check(lat == TURN_EXP + WP_EXP + 1, "R9 write latency", lat, TURN_EXP + WP_EXP + 1);
    else    check(lat == RD_EXP + 1, "R4 read latency", lat, RD_EXP + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_done,
          "R1 reset pins", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, rsp_done}, 6'b101100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_done, "R1 ready after reset", {req_ready, rsp_done}, 2'b10);

    do_access(1'b1, 17'h00000, 8'h5A, 1'b0);
    do_access(1'b1, 17'h1FFFF, 8'hA5, 1'b0);
    do_access(1'b0, 17'h00000, 8'h00, 1'b0);
    do_access(1'b0, 17'h1FFFF, 8'h00, 1'b0);

    // R2: stray write offered during a busy read must vanish
    do_access(1'b1, 17'h12345, 8'h3C, 1'b0);
    do_access(1'b0, 17'h12345, 8'h00, 1'b1);
    do_access(1'b0, 17'h12345, 8'h00, 1'b0);

    // read immediately followed by write: turnaround (R6)
    for (int i = 0; i < 8; i++) begin
      logic [16:0] a;
      a = 17'((i * 16411 + 7) & 32'h1FFFF);
      do_access(1'b1, a, 8'((i * 37 + 11) & 8'hFF), 1'b0);
      do_access(1'b0, a, 8'h00, 1'b0);
    end
    do_access(1'b1, 17'h00000, 8'h77, 1'b0);
    do_access(1'b0, 17'h00000, 8'h00, 1'b0);
    do_access(1'b0, 17'h1FFFF, 8'h00, 1'b0);

    repeat (4) @(negedge clk);
    check(dones == issued && sb_q.size() == 0, "R8 one done per access", dones, issued);
    check(req_ready && sram_ce1_n && !sram_ce2, "R1 idle at end", {req_ready, sram_ce1_n, sram_ce2}, 3'b110);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: dones=%0d expected=%0d", dones, issued);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule